// File: doc/BRIEF.md
# Double-Data-Rate Frame Receiver

This block sits at the acquisition end of a serial frame link. The link forwards a 160 MHz clock and carries one or two data lanes. Each lane changes on both edges of that clock. The receiver runs in the forwarded clock domain and takes two bits per lane in each clock period. It finds the start of a frame either from the rising edge of a marker line or by spotting the header word in the bit stream. It then rebuilds the 30-bit words, least significant bit first.

Each lane carries the same run of words: a header, then a trigger word, then a count word, then the payload, and last a trailer. The receiver checks the header and the trailer against constants set by parameters. It takes the frame counter and the payload length from the count word. In two-lane mode it merges the payload of the two lanes back into a single ordered stream.

Payload leaves as a valid/last stream of one word per valid cycle. The frame counter and the length sit beside the stream. Three sticky flags report a bad header, a bad trailer and a wrong length. Moving the data into a system clock domain is not part of this block, and neither is decoding the payload.

Top module: `ddr_frame_rx`

## Requirements
- R1: After reset `o_valid`, `o_last` and all three error flags are low, and stay low until a frame is received.
- R2: In each clock period, the bit sampled on the rising edge comes before the bit sampled on the following falling edge. Bit 0 of every 30-bit word is received first.
- R3: Each lane carries, in order: header, trigger word, count word, payload words, trailer. In the count word, bits [29:16] are the frame counter and bits [15:0] hold the per-lane payload count n. Bits [15:2] are the length in groups of four and bits [1:0] are the remainder, so n = length*4 + remainder. The payload leaves one word per valid cycle, in the order it was received.
- R4: With two lanes, payload word i of lane 0 is output before payload word i of lane 1, and that one before word i+1 of lane 0. The frame yields 2n words.
- R5: `o_last` is high on the final payload word of a frame and on no other word. A frame with n = 0 produces no output.
- R6: `o_frame_cnt` and `o_data_len` show the counter and n from the most recent count word, and do not change while a frame's words are being output.
- R7: With `use_marker` = 1, a frame starts at the clock period in which the marker, sampled on rising edges, goes from 0 to 1. That period's rising-edge bit is header bit 0. With `use_marker` = 0, a frame starts when the last 30 bits received on lane 0 equal the header constant, counted at a clock-period boundary.
- R8: A count word with n greater than MAX_WORDS (416) sets `o_err_length`. That frame outputs nothing, and the receiver returns to hunting. n = 416 is accepted.
- R9: A header that differs from the constant on any lane sets the sticky `o_err_header` and the frame outputs nothing. The next correct frame is received normally.
- R10: After n payload words have arrived, any word that is not the trailer on every lane sets `o_err_trailer`. So does a trailer on lane 0 that lane 1 does not match. In either case the held-back last word group is discarded, no `o_last` is given, and the receiver hunts again.
- R11: A trailer on all lanes that arrives after fewer than n payload words sets `o_err_length`. The words already received are still output, and `o_last` is on the final one.
- R12: The error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lane | input | 1 | Forwarded lane clock; data is sampled on both edges |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_din | input | LANES | Serial data, one bit per lane |
| marker | input | 1 | Frame marker; a rise marks header bit 0 |
| use_marker | input | 1 | 1: lock on the marker rise; 0: lock on the header pattern |
| o_valid | output | 1 | Payload word valid |
| o_data | output | WORD_W | Payload word |
| o_last | output | 1 | Final payload word of the frame |
| o_frame_cnt | output | CNT_W | Frame counter from the count word |
| o_data_len | output | WORD_W-CNT_W | Per-lane payload count n from the count word |
| o_err_header | output | 1 | Sticky header mismatch flag |
| o_err_trailer | output | 1 | Sticky trailer mismatch flag |
| o_err_length | output | 1 | Sticky length error flag |

## Verification
The bench sweeps the payload count from zero upward on one lane and on two lanes, and checks every word against its arithmetic value. A swapped edge order or a word built most significant bit first would show up as corrupt data. A lane merge in the wrong order would show up as pairs of words swapped. The bench runs frames at exactly 416 words and at 417. An off-by-one in the limit would either reject a legal frame or pass through a frame that should be rejected. It then corrupts the header, corrupts one lane's trailer, and sends frames that are short or long against their declared count. A design that mishandled these would output a dropped frame, give `o_last` on a broken frame, lose the words of a short frame, or fail to pick up the next good frame.

// File: rtl/ddr_frame_rx_pkg.sv
package ddr_frame_rx_pkg;

   // Position of the next expected word inside a lane's frame
   typedef enum logic [1:0] {
      SLOT_HDR,
      SLOT_TRG,
      SLOT_CNT,
      SLOT_PAY
   } slot_e;

   typedef enum logic {
      ST_HUNT,
      ST_RUN
   } rx_state_e;

endpackage

// File: rtl/ddr_lane_capture.sv
// Samples every lane on both clock edges; the pair is presented at the
// next rising edge with the rising-edge bit as the earlier one.
module ddr_lane_capture #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_din,
   input  logic             marker,
   output logic [LANES-1:0] bit_first,
   output logic [LANES-1:0] bit_second,
   output logic             mk_rise
);

   logic mk_q;
   logic mk_d;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_first[l] <= 1'b0;
         else        bit_first[l] <= lane_din[l];
      end

      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) bit_second[l] <= 1'b0;
         else        bit_second[l] <= lane_din[l];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mk_q <= 1'b0;
         mk_d <= 1'b0;
      end else begin
         mk_q <= marker;
         mk_d <= mk_q;
      end
   end

   assign mk_rise = mk_q & ~mk_d;

endmodule

// File: rtl/ddr_word_assembler.sv
// Shifts two bits per cycle into a word register, least significant bit
// first. The shift runs every cycle so the window doubles as the pattern
// search input; only the word counter is gated.
module ddr_word_assembler #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              en,
   input  logic              b_first,
   input  logic              b_second,
   output logic [WORD_W-1:0] window,
   output logic [WORD_W-1:0] word,
   output logic              word_vld
);

   localparam int HALF = WORD_W / 2;
   localparam int CW   = $clog2(HALF);
   localparam logic [CW-1:0] CNT_END = CW'(HALF - 1);

   logic [WORD_W-1:0] sh;
   logic [CW-1:0]     cnt;

   assign window = {b_second, b_first, sh[WORD_W-1:2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cnt      <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         sh       <= window;
         word_vld <= 1'b0;
         if (restart) begin
            cnt <= en ? CW'(1) : '0;
         end else if (en) begin
            if (cnt == CNT_END) begin
               cnt      <= '0;
               word     <= window;
               word_vld <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ddr_frame_parser.sv
// Frame state machine, service-word checks, payload hold-back and output.
module ddr_frame_parser
   import ddr_frame_rx_pkg::*;
#(
   parameter int                WORD_W    = 30,
   parameter int                LANES     = 2,
   parameter int                CNT_W     = 14,
   parameter int                MAX_WORDS = 416,
   parameter logic [WORD_W-1:0] HEADER    = '0,
   parameter logic [WORD_W-1:0] TRAILER   = '1,
   localparam int               LEN_W     = WORD_W - CNT_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          use_marker,
   input  logic                          mk_rise,
   input  logic [LANES-1:0][WORD_W-1:0]  win,
   input  logic [LANES-1:0][WORD_W-1:0]  words,
   input  logic                          word_vld,
   output logic                          asm_restart,
   output logic                          asm_en,
   output logic                          o_valid,
   output logic [WORD_W-1:0]             o_data,
   output logic                          o_last,
   output logic [CNT_W-1:0]              o_frame_cnt,
   output logic [LEN_W-1:0]              o_data_len,
   output logic                          o_err_header,
   output logic                          o_err_trailer,
   output logic                          o_err_length
);

   localparam logic [1:0]       LANE_CNT = 2'(LANES);
   localparam logic [LEN_W-1:0] MAX_N    = LEN_W'(MAX_WORDS);

   rx_state_e state;
   slot_e     slot;

   logic [LEN_W-1:0]             got;
   logic [LEN_W-1:0]             decl_n;
   logic [LANES-1:0][WORD_W-1:0] pend;
   logic [LANES-1:0][WORD_W-1:0] obuf;
   logic                         pend_full;
   logic [1:0]                   ocnt;
   logic                         osel;
   logic                         olast;
   logic [WORD_W-1:0]            out_word;

   logic hdr_win0, hdr_win_all, hdr_word_all, trl_word0, trl_word_all;

   always_comb begin
      hdr_win_all  = 1'b1;
      hdr_word_all = 1'b1;
      trl_word_all = 1'b1;
      for (int l = 0; l < LANES; l++) begin
         if (win[l]   != HEADER)  hdr_win_all  = 1'b0;
         if (words[l] != HEADER)  hdr_word_all = 1'b0;
         if (words[l] != TRAILER) trl_word_all = 1'b0;
      end
      hdr_win0  = (win[0] == HEADER);
      trl_word0 = (words[0] == TRAILER);
   end

   // Word counter control for the lane assemblers
   always_comb begin
      asm_restart = 1'b0;
      asm_en      = 1'b0;
      if (state == ST_RUN) begin
         asm_en = 1'b1;
      end else if (use_marker) begin
         asm_restart = mk_rise;
         asm_en      = mk_rise;
      end else begin
         asm_restart = hdr_win0;
      end
   end

   if (LANES == 2) begin : g_two
      assign out_word = osel ? obuf[1] : obuf[0];
   end else begin : g_one
      assign out_word = obuf[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_HUNT;
         slot          <= SLOT_HDR;
         got           <= '0;
         decl_n        <= '0;
         pend          <= '0;
         obuf          <= '0;
         pend_full     <= 1'b0;
         ocnt          <= '0;
         osel          <= 1'b0;
         olast         <= 1'b0;
         o_valid       <= 1'b0;
         o_data        <= '0;
         o_last        <= 1'b0;
         o_frame_cnt   <= '0;
         o_data_len    <= '0;
         o_err_header  <= 1'b0;
         o_err_trailer <= 1'b0;
         o_err_length  <= 1'b0;
      end else begin
         // Output stage: drains up to one word group, one word per cycle
         if (ocnt != 2'd0) begin
            o_valid <= 1'b1;
            o_data  <= out_word;
            o_last  <= olast && (ocnt == 2'd1);
            ocnt    <= ocnt - 2'd1;
            osel    <= 1'b1;
         end else begin
            o_valid <= 1'b0;
            o_last  <= 1'b0;
         end

         unique case (state)
            ST_HUNT: begin
               if (use_marker) begin
                  if (mk_rise) begin
                     state <= ST_RUN;
                     slot  <= SLOT_HDR;
                  end
               end else if (hdr_win0) begin
                  if (hdr_win_all) begin
                     state <= ST_RUN;
                     slot  <= SLOT_TRG;
                  end else begin
                     o_err_header <= 1'b1;
                  end
               end
            end

            ST_RUN: begin
               if (word_vld) begin
                  unique case (slot)
                     SLOT_HDR: begin
                        if (hdr_word_all) begin
                           slot <= SLOT_TRG;
                        end else begin
                           o_err_header <= 1'b1;
                           state        <= ST_HUNT;
                        end
                     end

                     SLOT_TRG: slot <= SLOT_CNT;

                     SLOT_CNT: begin
                        o_frame_cnt <= words[0][WORD_W-1:LEN_W];
                        o_data_len  <= words[0][LEN_W-1:0];
                        decl_n      <= words[0][LEN_W-1:0];
                        got         <= '0;
                        pend_full   <= 1'b0;
                        if (words[0][LEN_W-1:0] > MAX_N) begin
                           o_err_length <= 1'b1;
                           state        <= ST_HUNT;
                        end else begin
                           slot <= SLOT_PAY;
                        end
                     end

                     SLOT_PAY: begin
                        if (trl_word0) begin
                           if (!trl_word_all) begin
                              o_err_trailer <= 1'b1;
                           end else begin
                              if (got != decl_n) o_err_length <= 1'b1;
                              obuf  <= pend;
                              ocnt  <= pend_full ? LANE_CNT : 2'd0;
                              olast <= 1'b1;
                              osel  <= 1'b0;
                           end
                           pend_full <= 1'b0;
                           state     <= ST_HUNT;
                        end else if (got == decl_n) begin
                           o_err_trailer <= 1'b1;
                           pend_full     <= 1'b0;
                           state         <= ST_HUNT;
                        end else begin
                           obuf      <= pend;
                           ocnt      <= pend_full ? LANE_CNT : 2'd0;
                           olast     <= 1'b0;
                           osel      <= 1'b0;
                           pend      <= words;
                           pend_full <= 1'b1;
                           got       <= got + 1'b1;
                        end
                     end
                  endcase
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/ddr_frame_rx.sv
module ddr_frame_rx
   import ddr_frame_rx_pkg::*;
#(
   parameter int                WORD_W    = 30,
   parameter int                LANES     = 2,
   parameter int                CNT_W     = 14,
   parameter int                MAX_WORDS = 416,
   parameter logic [WORD_W-1:0] HEADER    = 30'h2C3A5F17,
   parameter logic [WORD_W-1:0] TRAILER   = 30'h3D1E88C4,
   localparam int               LEN_W     = WORD_W - CNT_W
) (
   input  logic              clk_lane,
   input  logic              rst_n,
   input  logic [LANES-1:0]  lane_din,
   input  logic              marker,
   input  logic              use_marker,
   output logic              o_valid,
   output logic [WORD_W-1:0] o_data,
   output logic              o_last,
   output logic [CNT_W-1:0]  o_frame_cnt,
   output logic [LEN_W-1:0]  o_data_len,
   output logic              o_err_header,
   output logic              o_err_trailer,
   output logic              o_err_length
);

   if (LANES < 1 || LANES > 2) begin : g_bad_lanes
      $error("ddr_frame_rx: LANES must be 1 or 2");
   end
   if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_word
      $error("ddr_frame_rx: WORD_W must be even and at least 4");
   end
   if (CNT_W < 1 || CNT_W >= WORD_W - 1) begin : g_bad_cnt
      $error("ddr_frame_rx: CNT_W leaves no room for the length field");
   end
   if (MAX_WORDS < 1 || MAX_WORDS >= (2 ** LEN_W)) begin : g_bad_max
      $error("ddr_frame_rx: MAX_WORDS does not fit the length field");
   end

   logic [LANES-1:0]             bit_first;
   logic [LANES-1:0]             bit_second;
   logic                         mk_rise;
   logic                         asm_restart;
   logic                         asm_en;
   logic [LANES-1:0][WORD_W-1:0] win;
   logic [LANES-1:0][WORD_W-1:0] words;
   logic [LANES-1:0]             vld;

   ddr_lane_capture #(.LANES(LANES)) u_capture (
      .clk        (clk_lane),
      .rst_n      (rst_n),
      .lane_din   (lane_din),
      .marker     (marker),
      .bit_first  (bit_first),
      .bit_second (bit_second),
      .mk_rise    (mk_rise)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_asm
      ddr_word_assembler #(.WORD_W(WORD_W)) u_asm (
         .clk      (clk_lane),
         .rst_n    (rst_n),
         .restart  (asm_restart),
         .en       (asm_en),
         .b_first  (bit_first[l]),
         .b_second (bit_second[l]),
         .window   (win[l]),
         .word     (words[l]),
         .word_vld (vld[l])
      );
   end

   ddr_frame_parser #(
      .WORD_W    (WORD_W),
      .LANES     (LANES),
      .CNT_W     (CNT_W),
      .MAX_WORDS (MAX_WORDS),
      .HEADER    (HEADER),
      .TRAILER   (TRAILER)
   ) u_parser (
      .clk           (clk_lane),
      .rst_n         (rst_n),
      .use_marker    (use_marker),
      .mk_rise       (mk_rise),
      .win           (win),
      .words         (words),
      .word_vld      (&vld),
      .asm_restart   (asm_restart),
      .asm_en        (asm_en),
      .o_valid       (o_valid),
      .o_data        (o_data),
      .o_last        (o_last),
      .o_frame_cnt   (o_frame_cnt),
      .o_data_len    (o_data_len),
      .o_err_header  (o_err_header),
      .o_err_trailer (o_err_trailer),
      .o_err_length  (o_err_length)
   );

endmodule

module ddr_frame_rx_chk #(
   parameter int LEN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             o_valid,
   input logic             o_last,
   input logic [LEN_W-1:0] o_data_len,
   input logic             o_err_header,
   input logic             o_err_trailer,
   input logic             o_err_length
);

   p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      o_last |-> o_valid)
      else $error("o_last without o_valid");

   p_gap_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      o_last |=> !o_valid)
      else $error("word output right after o_last");

   p_len_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $past(o_valid)) |-> $stable(o_data_len))
      else $error("o_data_len changed inside a burst");

   p_hdr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      o_err_header |=> o_err_header)
      else $error("header flag cleared");

   p_trl_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      o_err_trailer |=> o_err_trailer)
      else $error("trailer flag cleared");

   p_len_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      o_err_length |=> o_err_length)
      else $error("length flag cleared");

endmodule

bind ddr_frame_rx ddr_frame_rx_chk #(.LEN_W(LEN_W)) u_chk (
   .clk           (clk_lane),
   .rst_n         (rst_n),
   .o_valid       (o_valid),
   .o_last        (o_last),
   .o_data_len    (o_data_len),
   .o_err_header  (o_err_header),
   .o_err_trailer (o_err_trailer),
   .o_err_length  (o_err_length)
);

// File: tb/ddr_frame_rx_bench.sv
module ddr_frame_rx_bench;

   localparam logic [29:0] HDR = 30'h2C3A5F17;
   localparam logic [29:0] TRL = 30'h3D1E88C4;
   localparam logic [29:0] TRG = 30'h0001234;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] din = 2'b00;
   logic       mk = 1'b0;
   logic       usem = 1'b1;

   always #10 clk = ~clk;

   logic        a_valid, a_last, a_eh, a_et, a_el;
   logic [29:0] a_data;
   logic [13:0] a_fc;
   logic [15:0] a_len;
   logic        b_valid, b_last, b_eh, b_et, b_el;
   logic [29:0] b_data;
   logic [13:0] b_fc;
   logic [15:0] b_len;

   ddr_frame_rx #(.LANES(2), .HEADER(HDR), .TRAILER(TRL)) u_ddr_frame_rx (
      .clk_lane(clk), .rst_n(rst_n), .lane_din(din), .marker(mk), .use_marker(usem),
      .o_valid(a_valid), .o_data(a_data), .o_last(a_last), .o_frame_cnt(a_fc),
      .o_data_len(a_len), .o_err_header(a_eh), .o_err_trailer(a_et), .o_err_length(a_el));

   ddr_frame_rx #(.LANES(1), .HEADER(HDR), .TRAILER(TRL)) u_ddr_frame_rx_single (
      .clk_lane(clk), .rst_n(rst_n), .lane_din(din[0:0]), .marker(mk), .use_marker(usem),
      .o_valid(b_valid), .o_data(b_data), .o_last(b_last), .o_frame_cnt(b_fc),
      .o_data_len(b_len), .o_err_header(b_eh), .o_err_trailer(b_et), .o_err_length(b_el));

   logic [29:0] qa_d[$];
   bit          qa_l[$];
   logic [29:0] qb_d[$];
   bit          qb_l[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (a_valid) begin qa_d.push_back(a_data); qa_l.push_back(a_last); end
         if (b_valid) begin qb_d.push_back(b_data); qb_l.push_back(b_last); end
      end
   end

   int nchk = 0;
   int nerr = 0;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [29:0] pay(input int seed, input int k);
      return 30'((seed * 7919 + k * 37 + 5) & 32'hFFFFF);
   endfunction

   task automatic clear_q();
      qa_d.delete(); qa_l.delete(); qb_d.delete(); qb_l.delete();
   endtask

   // First bit is set before the rising edge, second before the falling edge
   task automatic send_pair(input logic [1:0] f, input logic [1:0] s, input logic m);
      @(negedge clk); #5;
      din = f; mk = m;
      @(posedge clk); #5;
      din = s;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) send_pair(2'b00, 2'b00, 1'b0);
   endtask

   task automatic send_word(input logic [29:0] w0, input logic [29:0] w1, input logic m);
      for (int i = 0; i < 15; i++)
         send_pair({w1[2*i], w0[2*i]}, {w1[2*i+1], w0[2*i+1]}, m && (i == 0));
   endtask

   task automatic send_frame(input int lanes, input int seed, input int m, input int decl,
                             input logic [29:0] h0, input logic [29:0] h1,
                             input logic [29:0] t0, input logic [29:0] t1, input logic mflag);
      logic [29:0] fcw;
      fcw = {14'(seed + 100), 16'(decl)};
      send_word(h0, h1, mflag);
      send_word(TRG, TRG, 1'b0);
      send_word(fcw, fcw, 1'b0);
      for (int i = 0; i < m; i++)
         send_word(pay(seed, i * lanes), pay(seed, i * lanes + lanes - 1), 1'b0);
      send_word(t0, t1, 1'b0);
      idle(12);
   endtask

   task automatic do_reset();
      @(negedge clk); #5;
      rst_n = 1'b0; din = 2'b00; mk = 1'b0;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      clear_q();
   endtask

   task automatic check_out(input int tgt, input int seed, input int total,
                            input bit want_last, input string tag);
      int sz;
      logic [29:0] d;
      bit l;
      sz = tgt ? qb_d.size() : qa_d.size();
      chk(sz == total, $sformatf("%s word count", tag), sz, total);
      for (int k = 0; k < sz && k < total; k++) begin
         d = tgt ? qb_d[k] : qa_d[k];
         l = tgt ? qb_l[k] : qa_l[k];
         chk(d == pay(seed, k), $sformatf("%s data word %0d", tag, k), d, pay(seed, k));
         chk(l == (want_last && k == total - 1), $sformatf("%s last flag word %0d", tag, k),
             l, (want_last && k == total - 1));
      end
   endtask

   task automatic run_all();
      do_reset();
      // R1: idle state after reset
      chk(!a_valid && !a_last && !b_valid && !b_last, "R1 valid/last after reset",
          {a_valid, a_last, b_valid, b_last}, 0);
      chk(!a_eh && !a_et && !a_el && !b_eh && !b_et && !b_el, "R1 flags after reset",
          {a_eh, a_et, a_el, b_eh, b_et, b_el}, 0);

      // R2 R3 R5 R6: one lane, marker mode, n swept 0..9
      usem = 1'b1;
      for (int n = 0; n < 10; n++) begin
         clear_q();
         send_frame(1, n, n, n, HDR, HDR, TRL, TRL, 1'b1);
         check_out(1, n, n, 1'b1, $sformatf("R2 R3 R5 single n=%0d", n));
         chk(b_fc == 14'(n + 100), "R6 frame counter", b_fc, n + 100);
         chk(b_len == 16'(n), "R6 data length", b_len, n);
      end
      chk(!b_eh && !b_et && !b_el, "R1 no flags after good frames", {b_eh, b_et, b_el}, 0);

      // R4: two lanes, interleaved order, n swept 0..6
      do_reset();
      for (int n = 0; n < 7; n++) begin
         clear_q();
         send_frame(2, 20 + n, n, n, HDR, HDR, TRL, TRL, 1'b1);
         check_out(0, 20 + n, 2 * n, 1'b1, $sformatf("R4 dual n=%0d", n));
         chk(a_len == 16'(n), "R6 dual data length", a_len, n);
      end
      chk(!a_eh && !a_et && !a_el, "R4 no flags on dual frames", {a_eh, a_et, a_el}, 0);

      // R7: pattern lock with noise in front
      do_reset();
      usem = 1'b0;
      for (int n = 3; n < 6; n++) begin
         clear_q();
         for (int i = 0; i < 7; i++) send_pair(2'b11, 2'b00, 1'b0);
         send_frame(1, 40 + n, n, n, HDR, HDR, TRL, TRL, 1'b0);
         check_out(1, 40 + n, n, 1'b1, $sformatf("R7 pattern single n=%0d", n));
      end
      do_reset();
      clear_q();
      for (int i = 0; i < 5; i++) send_pair(2'b01, 2'b10, 1'b0);
      send_frame(2, 47, 3, 3, HDR, HDR, TRL, TRL, 1'b0);
      check_out(0, 47, 6, 1'b1, "R7 pattern dual");
      usem = 1'b1;

      // R8: limit at 416 accepted, 417 rejected
      do_reset();
      send_frame(1, 50, 416, 416, HDR, HDR, TRL, TRL, 1'b1);
      check_out(1, 50, 416, 1'b1, "R8 n=416");
      chk(!b_el, "R8 no length flag at 416", b_el, 0);
      clear_q();
      send_frame(1, 51, 3, 417, HDR, HDR, TRL, TRL, 1'b1);
      chk(qb_d.size() == 0, "R8 n=417 output count", qb_d.size(), 0);
      chk(b_el, "R8 length flag at 417", b_el, 1);

      // R9: bad header dropped, next frame received, flag held (R12)
      do_reset();
      send_frame(1, 60, 3, 3, HDR ^ 30'h1, HDR, TRL, TRL, 1'b1);
      chk(qb_d.size() == 0, "R9 dropped frame output count", qb_d.size(), 0);
      chk(b_eh, "R9 header flag", b_eh, 1);
      clear_q();
      send_frame(1, 61, 2, 2, HDR, HDR, TRL, TRL, 1'b1);
      check_out(1, 61, 2, 1'b1, "R9 recovery frame");
      chk(b_eh, "R12 header flag held", b_eh, 1);

      // R10: lane 1 trailer corrupt
      do_reset();
      send_frame(2, 70, 3, 3, HDR, HDR, TRL, TRL ^ 30'h4, 1'b1);
      check_out(0, 70, 4, 1'b0, "R10 dual bad trailer");
      chk(a_et && !a_el, "R10 trailer flag only", {a_et, a_el}, 2);

      // R10: more words than declared
      do_reset();
      send_frame(1, 71, 4, 2, HDR, HDR, TRL, TRL, 1'b1);
      check_out(1, 71, 1, 1'b0, "R10 long frame");
      chk(b_et, "R10 trailer flag on long frame", b_et, 1);

      // R11: fewer words than declared
      do_reset();
      send_frame(1, 80, 3, 5, HDR, HDR, TRL, TRL, 1'b1);
      check_out(1, 80, 3, 1'b1, "R11 short frame");
      chk(b_el && !b_et, "R11 length flag only", {b_el, b_et}, 2);
      idle(20);
      chk(b_el, "R12 length flag held", b_el, 1);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule